// File: doc/BRIEF.md
# Receive Buffer Pause Watermark Controller

This block watches how many bytes sit in a receive buffer and tells the transmit side when to send IEEE 802.3x PAUSE frames. When the fill reaches the high threshold it raises a one-cycle pause request. The request carries the pause time in 512-bit-time quanta. While the fill stays at or above the low threshold, the block repeats the pause before the link partner's timer runs out. Once the fill drops below the low threshold, it raises a single zero-quanta resume request.

Both thresholds are programmed in 8-byte units. A high threshold of zero turns flow control off. A separate enable must also be high before any request leaves the block. The pause time comes from an input; a programmed value of zero selects 0xF000. A prescaler counts clock cycles into pause quanta, and that count times the refresh. Building the frame and driving the MAC are done elsewhere.

Top module: `rxfifo_pause_ctrl`

## Requirements
- R1: Thresholds are in 8-byte units. With flow control on and no pause outstanding, a fill of at least 8*hwm_i bytes gives a pause pulse one clock later. A fill one byte below that gives no pulse.
- R2: While hwm_i is 0, no pause or resume is produced. Any outstanding pause is dropped without a resume, so re-enabling with a high fill pauses again at once.
- R3: While tx_pause_en_i is low, no pause or resume is produced, and any outstanding pause is dropped without a resume.
- R4: While a pause is outstanding, crossing the high threshold again produces no new pause. A new threshold pause needs a resume first.
- R5: When the fill falls below 8*lwm_i bytes with a pause outstanding, exactly one resume pulse is produced one clock later. During that pulse pause_quanta_o is 0.
- R6: While a pause is outstanding and the fill is at least 8*lwm_i bytes, the pause is repeated every H*CLK_PER_QUANTUM cycles, where H = max(Q/2, 1) and Q is the effective pause time.
- R7: During a pause pulse, pause_quanta_o equals quanta_i, or 0xF000 when quanta_i is 0. Between pulses pause_quanta_o holds its value.
- R8: If a refresh falls due in the same cycle that the fill is below the low threshold, only the resume is produced.
- R9: During reset and right after it, pause_req_o, resume_req_o and pause_quanta_o are 0.
- R10: pause_req_o and resume_req_o are never high together, and a resume pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_bytes_i | input | FILL_W | Receive buffer occupancy in bytes |
| lwm_i | input | WM_W | Low threshold, 8-byte units |
| hwm_i | input | WM_W | High threshold, 8-byte units; 0 turns flow control off |
| tx_pause_en_i | input | 1 | Allows pause frames to be requested |
| quanta_i | input | 16 | Pause time in quanta; 0 selects 0xF000 |
| pause_req_o | output | 1 | One-cycle pause request |
| resume_req_o | output | 1 | One-cycle zero-quanta resume request |
| pause_quanta_o | output | 16 | Quanta value for the current request |

## Verification
Two functions can fall due in the same cycle: the periodic refresh and the drop below the low threshold. The bench provokes this by keeping the fill high for exactly one clock less than the refresh interval after a pause. It then lowers the fill for the very edge on which the refresh would fire. The check passes only if that edge gives a resume pulse with zero quanta and no pause pulse.

// File: rtl/pause_wm_pkg.sv
package pause_wm_pkg;
  localparam int unsigned QUANTA_W = 16;
  localparam logic [QUANTA_W-1:0] DEFAULT_QUANTA = 16'hF000;
  localparam int unsigned WM_UNIT_SHIFT = 3;  // 8-byte threshold granularity
endpackage

// File: rtl/pause_wm_compare.sv
module pause_wm_compare
  import pause_wm_pkg::*;
#(
  parameter int unsigned FILL_W = 16,
  parameter int unsigned WM_W   = 13
) (
  input  logic [FILL_W-1:0] fill_i,
  input  logic [WM_W-1:0]   lwm_i,
  input  logic [WM_W-1:0]   hwm_i,
  output logic              at_hwm_o,
  output logic              below_lwm_o,
  output logic              hwm_set_o
);
  localparam int unsigned SW  = WM_W + WM_UNIT_SHIFT;
  localparam int unsigned CMP_W = (FILL_W > SW) ? FILL_W : SW;

  logic [CMP_W-1:0] fill_x, lwm_x, hwm_x;

  assign fill_x = CMP_W'(fill_i);
  assign lwm_x  = CMP_W'({lwm_i, {WM_UNIT_SHIFT{1'b0}}});
  assign hwm_x  = CMP_W'({hwm_i, {WM_UNIT_SHIFT{1'b0}}});

  assign at_hwm_o    = fill_x >= hwm_x;
  assign below_lwm_o = fill_x < lwm_x;
  assign hwm_set_o   = |hwm_i;
endmodule

// File: rtl/pause_quanta_timer.sv
module pause_quanta_timer
  import pause_wm_pkg::*;
#(
  parameter int unsigned CLK_PER_QUANTUM = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                restart_i,
  input  logic [QUANTA_W-1:0] half_i,   // refresh point in quanta, >= 1
  output logic                due_o
);
  localparam int unsigned PW = (CLK_PER_QUANTUM > 1) ? $clog2(CLK_PER_QUANTUM) : 1;

  logic                wrap;
  logic [QUANTA_W-1:0] qcnt_q;

  generate
    if (CLK_PER_QUANTUM > 1) begin : g_presc
      logic [PW-1:0] presc_q;
      assign wrap = presc_q == PW'(CLK_PER_QUANTUM - 1);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         presc_q <= '0;
        else if (restart_i)  presc_q <= '0;
        else if (wrap)       presc_q <= '0;
        else                 presc_q <= presc_q + 1'b1;
      end
    end else begin : g_no_presc
      assign wrap = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         qcnt_q <= '0;
    else if (restart_i)  qcnt_q <= '0;
    else if (wrap)       qcnt_q <= qcnt_q + 1'b1;
  end

  assign due_o = wrap && (qcnt_q == half_i - 1'b1);
endmodule

// File: rtl/rxfifo_pause_ctrl.sv
module rxfifo_pause_ctrl
  import pause_wm_pkg::*;
#(
  parameter int unsigned FILL_W          = 16,
  parameter int unsigned WM_W            = 13,
  parameter int unsigned CLK_PER_QUANTUM = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [FILL_W-1:0]   fill_bytes_i,
  input  logic [WM_W-1:0]     lwm_i,
  input  logic [WM_W-1:0]     hwm_i,
  input  logic                tx_pause_en_i,
  input  logic [QUANTA_W-1:0] quanta_i,
  output logic                pause_req_o,
  output logic                resume_req_o,
  output logic [QUANTA_W-1:0] pause_quanta_o
);
  logic                at_hwm, below_lwm, hwm_set, fc_on;
  logic                paused_q, due;
  logic                fire_pause, fire_resume;
  logic [QUANTA_W-1:0] eff_quanta, half_quanta;

  pause_wm_compare #(.FILL_W(FILL_W), .WM_W(WM_W)) u_cmp (
    .fill_i      (fill_bytes_i),
    .lwm_i       (lwm_i),
    .hwm_i       (hwm_i),
    .at_hwm_o    (at_hwm),
    .below_lwm_o (below_lwm),
    .hwm_set_o   (hwm_set)
  );

  assign eff_quanta  = (quanta_i == '0) ? DEFAULT_QUANTA : quanta_i;
  assign half_quanta = (eff_quanta[QUANTA_W-1:1] == '0) ? QUANTA_W'(1)
                                                        : {1'b0, eff_quanta[QUANTA_W-1:1]};

  pause_quanta_timer #(.CLK_PER_QUANTUM(CLK_PER_QUANTUM)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (fire_pause),
    .half_i    (half_quanta),
    .due_o     (due)
  );

  assign fc_on = hwm_set && tx_pause_en_i;

  // resume outranks refresh when both fall due
  always_comb begin
    fire_resume = fc_on && paused_q && below_lwm;
    fire_pause  = fc_on && ((!paused_q && at_hwm) ||
                            (paused_q && !below_lwm && due));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paused_q       <= 1'b0;
      pause_req_o    <= 1'b0;
      resume_req_o   <= 1'b0;
      pause_quanta_o <= '0;
    end else begin
      pause_req_o  <= fire_pause;
      resume_req_o <= fire_resume;
      if (!fc_on)           paused_q <= 1'b0;
      else if (fire_pause)  paused_q <= 1'b1;
      else if (fire_resume) paused_q <= 1'b0;
      if (fire_pause)       pause_quanta_o <= eff_quanta;
      else if (fire_resume) pause_quanta_o <= '0;
    end
  end
endmodule

// File: rtl/rxfifo_pause_ctrl_chk.sv
module rxfifo_pause_ctrl_chk
  import pause_wm_pkg::*;
#(
  parameter int unsigned WM_W = 13
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                tx_pause_en_i,
  input logic [WM_W-1:0]     hwm_i,
  input logic                pause_req_o,
  input logic                resume_req_o,
  input logic [QUANTA_W-1:0] pause_quanta_o
);
  p_one_kind_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pause_req_o && resume_req_o));

  p_resume_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_req_o |=> !resume_req_o);

  p_hwm_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hwm_i == '0) |=> (!pause_req_o && !resume_req_o));

  p_en_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_pause_en_i |=> (!pause_req_o && !resume_req_o));

  p_resume_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_req_o |-> (pause_quanta_o == '0));

  p_pause_nonzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_req_o |-> (pause_quanta_o != '0));

  p_quanta_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pause_req_o && !resume_req_o) |-> $stable(pause_quanta_o));
endmodule

bind rxfifo_pause_ctrl rxfifo_pause_ctrl_chk #(.WM_W(WM_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .tx_pause_en_i  (tx_pause_en_i),
  .hwm_i          (hwm_i),
  .pause_req_o    (pause_req_o),
  .resume_req_o   (resume_req_o),
  .pause_quanta_o (pause_quanta_o)
);

// File: tb/rxfifo_pause_ctrl_tb_top.sv
module rxfifo_pause_ctrl_tb_top;
  localparam int CPQ = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] fill = '0;
  logic [12:0] lwm = 13'd8;    // 64 bytes
  logic [12:0] hwm = 13'd16;   // 128 bytes
  logic        en = 1'b1;
  logic [15:0] quanta = '0;
  logic        p_o, r_o;
  logic [15:0] q_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  rxfifo_pause_ctrl #(.FILL_W(16), .WM_W(13), .CLK_PER_QUANTUM(CPQ)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fill_bytes_i(fill), .lwm_i(lwm), .hwm_i(hwm),
    .tx_pause_en_i(en), .quanta_i(quanta),
    .pause_req_o(p_o), .resume_req_o(r_o), .pause_quanta_o(q_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] f, input bit ep, input bit er,
                      input logic [15:0] eq, input string tag);
    @(negedge clk);
    fill = f;
    @(posedge clk);
    #1;
    chk({tag, " pause"}, 32'(p_o), 32'(ep));
    chk({tag, " resume"}, 32'(r_o), 32'(er));
    if (ep || er) chk({tag, " quanta"}, 32'(q_o), 32'(eq));
  endtask

  // {fill, exp_pause, exp_resume}; quanta_i = 0 so pauses carry 0xF000
  localparam int NV = 12;
  localparam logic [17:0] VEC [NV] = '{
    {16'd0,   1'b0, 1'b0},
    {16'd127, 1'b0, 1'b0},   // R1 one below 8*hwm
    {16'd128, 1'b1, 1'b0},   // R1 at 8*hwm
    {16'd300, 1'b0, 1'b0},   // R4
    {16'd127, 1'b0, 1'b0},
    {16'd128, 1'b0, 1'b0},   // R4 re-cross
    {16'd64,  1'b0, 1'b0},   // at 8*lwm
    {16'd63,  1'b0, 1'b1},   // R5
    {16'd63,  1'b0, 1'b0},   // R5 once
    {16'd500, 1'b1, 1'b0},
    {16'd0,   1'b0, 1'b1},
    {16'd0,   1'b0, 1'b0}
  };

  initial begin
    #5;
    chk("R9 in reset pause", 32'(p_o), 0);
    chk("R9 in reset resume", 32'(r_o), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R9 after reset pause", 32'(p_o), 0);
    chk("R9 after reset resume", 32'(r_o), 0);
    chk("R9 after reset quanta", 32'(q_o), 0);

    for (int i = 0; i < NV; i++)
      step(VEC[i][17:2], VEC[i][1], VEC[i][0], VEC[i][1] ? 16'hF000 : 16'h0, "R1/R4/R5/R7 table");

    // R7 programmed quanta, R6 refresh at 3*CPQ
    quanta = 16'd6;
    step(16'd200, 1'b1, 1'b0, 16'd6, "R7 programmed");
    for (int k = 1; k < 3 * CPQ; k++) step(16'd200, 1'b0, 1'b0, 16'd0, "R6 wait");
    step(16'd200, 1'b1, 1'b0, 16'd6, "R6 refresh");
    // R8 collision: drop below lwm on the edge the refresh is due
    for (int k = 1; k < 3 * CPQ; k++) step(16'd200, 1'b0, 1'b0, 16'd0, "R8 wait");
    step(16'd10, 1'b0, 1'b1, 16'd0, "R8 resume wins");
    step(16'd10, 1'b0, 1'b0, 16'd0, "R10 single resume");

    // R6 floor of one quantum
    quanta = 16'd1;
    step(16'd200, 1'b1, 1'b0, 16'd1, "R6 floor first");
    for (int k = 1; k < CPQ; k++) step(16'd200, 1'b0, 1'b0, 16'd0, "R6 floor wait");
    step(16'd200, 1'b1, 1'b0, 16'd1, "R6 floor refresh");
    step(16'd0, 1'b0, 1'b1, 16'd0, "R5 resume");

    // R2 hwm zero
    quanta = 16'd0;
    hwm = '0;
    step(16'd500, 1'b0, 1'b0, 16'd0, "R2 disabled high fill");
    hwm = 13'd16;
    step(16'd500, 1'b1, 1'b0, 16'hF000, "R2 enabled pause");
    hwm = '0;
    step(16'd500, 1'b0, 1'b0, 16'd0, "R2 hold");
    step(16'd0, 1'b0, 1'b0, 16'd0, "R2 no resume");
    hwm = 13'd16;
    step(16'd500, 1'b1, 1'b0, 16'hF000, "R2 pause dropped");

    // R3 enable low
    en = 1'b0;
    step(16'd0, 1'b0, 1'b0, 16'd0, "R3 no resume");
    step(16'd500, 1'b0, 1'b0, 16'd0, "R3 no pause");
    en = 1'b1;
    step(16'd0, 1'b0, 1'b0, 16'd0, "R3 re-enabled low");
    step(16'd500, 1'b1, 1'b0, 16'hF000, "R3 re-enabled pause");
    chk("R10 hold quanta", 32'(q_o), 32'h0000F000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule